// File: doc/BRIEF.md
# Sample Chunk Burst Writer with Loss Detection

This block sits between a sample capture front end and a memory write port. The front end hands over 32-byte chunks of packed samples one at a time. Each chunk comes with a running byte total kept by the producer. The block stores the chunk in a single holding register. It then writes the chunk to memory as one fixed-length burst and steps the write address by 32 bytes. The memory area is a ring of equal segments that starts at a programmed base. When the last segment has been written, the address returns to the base, so capture can run without a break. In one-shot mode the block stops instead, once a programmed number of bytes has been written.

Two loss checks run all the time. On the input side, the byte total of each chunk is compared with the total of the chunk before it. A step of more than one chunk means that samples were dropped upstream. A front end that finds the block not ready is also treated as losing data, because a real-time producer cannot wait. On the host side, every filled segment raises a one-cycle notification and increments a notification counter. The host returns acknowledgements. If a segment completes while the host already holds a full ring of unacknowledged segments, the host has fallen behind and data it had not read was overwritten.

The input and output data paths are valid/ready streams. A beat or chunk moves only in a cycle where both valid and ready are high. The side that drives valid must hold its payload stable until that cycle. Configuration, start, clear, acknowledgement and the status flags are plain level or pulse signals.

Top module: `cw_chunk_writer`

## Requirements
- R1: Each accepted chunk is written as DATA_W/8-byte beats, four beats with the default 64-bit data path. Chunk byte b sits in beat b/(DATA_W/8), in lane byte b mod (DATA_W/8), so byte 0 is in bits 7:0 of the first beat. wr_last is high on the final beat only. wr_addr holds the chunk's address for the whole burst.
- R2: The burst is a valid/ready stream. While wr_valid is high and wr_ready is low, wr_addr, wr_data and wr_last stay unchanged. A beat advances only when both are high.
- R3: The k-th chunk after start (k from 0) is written at cfg_base + 32*(k mod (cfg_seg_chunks*cfg_nseg)). After the final chunk of the final segment, the address returns to cfg_base.
- R4: When a chunk is accepted, in_count minus the in_count of the previous accepted chunk is computed modulo 2^CNT_W. The previous value is taken as 0 for the first chunk after start. If the result is greater than 32, overflow is set. A step of exactly 32 leaves overflow unchanged.
- R5: While a run is active, any cycle with in_valid high and in_ready low sets overflow.
- R6: overflow and underflow are sticky. A clr_flags pulse clears them, unless a new setting event occurs in the same cycle; the new event wins. start does not clear them.
- R7: In the cycle after the final beat of a segment's last chunk is accepted, irq is high for exactly one cycle and notify_cnt has grown by one.
- R8: At each segment completion, the block compares (notify_cnt minus the acknowledged count) with cfg_nseg, before counting the new segment. If the difference is greater than or equal to cfg_nseg, underflow is set. Each host_ack pulse acknowledges one segment. A pulse with no segment outstanding is ignored.
- R9: With cfg_oneshot high, the block stops at the final beat that brings the bytes written since start to at least cfg_limit. done then rises, and in_ready stays low until the next start.
- R10: After reset, in_ready, wr_valid, irq, done, overflow and underflow are low and notify_cnt is 0. A start pulse clears the address, the segment counters, the previous count, the notification and acknowledgement counts, and done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse: begin a new run from cfg_base |
| clr_flags | input | 1 | Pulse: clear the sticky overflow and underflow flags |
| cfg_base | input | ADDR_W | Ring base byte address, 32-byte aligned |
| cfg_seg_chunks | input | SEG_W | Chunks per segment, at least 1 |
| cfg_nseg | input | SEG_W | Segments in the ring, at least 1 |
| cfg_oneshot | input | 1 | Stop after cfg_limit bytes instead of wrapping forever |
| cfg_limit | input | CNT_W | One-shot byte limit, at least 32 |
| in_valid | input | 1 | Chunk offered |
| in_ready | output | 1 | Holding register can take a chunk |
| in_data | input | 256 | Chunk payload, byte 0 in bits 7:0 |
| in_count | input | CNT_W | Producer running byte total that comes with the chunk |
| wr_valid | output | 1 | Write beat valid |
| wr_ready | input | 1 | Memory accepts the beat |
| wr_addr | output | ADDR_W | Byte address of the chunk being written |
| wr_data | output | DATA_W | Beat payload |
| wr_last | output | 1 | Final beat of the burst |
| host_ack | input | 1 | Pulse: host has consumed one segment |
| irq | output | 1 | One-cycle segment-filled notification |
| notify_cnt | output | NTF_W | Notifications since start |
| overflow | output | 1 | Sticky input-loss flag |
| underflow | output | 1 | Sticky host-behind flag |
| done | output | 1 | One-shot run finished |

## Verification
The bench runs a ring of three two-chunk segments through more than two full wraps. The memory side stalls in a rotating pattern, so wrap placement and beat ordering are tested under back-pressure. A wrong wrap would send the seventh chunk past the ring, and a misrouted lane would appear as corrupt bytes on a particular beat. For the count check, it uses both a step of exactly one chunk and a step of two chunks. An off-by-one comparison would either flag every normal chunk or miss a one-chunk gap. A flag that is not sticky would drop after the next good chunk. The host side is tested by withholding acknowledgements until the fourth segment. A design that counts the delta wrongly would flag one segment early or one late. The one-shot limit is tested at the chunk that reaches the limit exactly. If the block keeps in_ready high after done, it could accept a chunk it will never write.

// File: rtl/cw_pkg.sv
package cw_pkg;
  localparam int CHUNK_BYTES = 32;
  localparam int CHUNK_BITS  = CHUNK_BYTES * 8;
endpackage

// File: rtl/cw_count_check.sv
module cw_count_check
  import cw_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart_i,
  input  logic             take_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             gap_o
);
  logic [CNT_W-1:0] prev_q;
  logic [CNT_W-1:0] step;

  assign step  = count_i - prev_q;
  assign gap_o = take_i && (step > CNT_W'(CHUNK_BYTES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         prev_q <= '0;
    else if (restart_i) prev_q <= '0;
    else if (take_i)    prev_q <= count_i;
  end
endmodule

// File: rtl/cw_addr_gen.sv
module cw_addr_gen
  import cw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SEG_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart_i,
  input  logic              advance_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [SEG_W-1:0]  seg_chunks_i,
  input  logic [SEG_W-1:0]  nseg_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              seg_end_o
);
  logic [ADDR_W-1:0] ofs_q;
  logic [SEG_W-1:0]  chunk_q;
  logic [SEG_W-1:0]  seg_q;
  logic              last_chunk, last_seg;

  assign last_chunk = (chunk_q == seg_chunks_i - SEG_W'(1));
  assign last_seg   = (seg_q == nseg_i - SEG_W'(1));
  assign seg_end_o  = advance_i && last_chunk;
  assign addr_o     = base_i + ofs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ofs_q   <= '0;
      chunk_q <= '0;
      seg_q   <= '0;
    end else if (restart_i) begin
      ofs_q   <= '0;
      chunk_q <= '0;
      seg_q   <= '0;
    end else if (advance_i) begin
      if (last_chunk) begin
        chunk_q <= '0;
        if (last_seg) begin
          seg_q <= '0;
          ofs_q <= '0;
        end else begin
          seg_q <= seg_q + SEG_W'(1);
          ofs_q <= ofs_q + ADDR_W'(CHUNK_BYTES);
        end
      end else begin
        chunk_q <= chunk_q + SEG_W'(1);
        ofs_q   <= ofs_q + ADDR_W'(CHUNK_BYTES);
      end
    end
  end
endmodule

// File: rtl/cw_notify.sv
module cw_notify #(
  parameter int SEG_W = 8,
  parameter int NTF_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart_i,
  input  logic             seg_done_i,
  input  logic             ack_i,
  input  logic [SEG_W-1:0] nseg_i,
  output logic             irq_o,
  output logic [NTF_W-1:0] count_o,
  output logic             behind_o
);
  logic [NTF_W-1:0] ntf_q, ack_q, pending;

  assign pending  = ntf_q - ack_q;
  assign behind_o = seg_done_i && (pending >= NTF_W'(nseg_i));
  assign count_o  = ntf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ntf_q <= '0;
      ack_q <= '0;
      irq_o <= 1'b0;
    end else if (restart_i) begin
      ntf_q <= '0;
      ack_q <= '0;
      irq_o <= 1'b0;
    end else begin
      irq_o <= seg_done_i;
      if (seg_done_i) ntf_q <= ntf_q + NTF_W'(1);
      if (ack_i && (pending != '0)) ack_q <= ack_q + NTF_W'(1);
    end
  end
endmodule

// File: rtl/cw_chunk_writer.sv
module cw_chunk_writer
  import cw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int CNT_W  = 32,
  parameter int SEG_W  = 8,
  parameter int NTF_W  = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  clr_flags,
  input  logic [ADDR_W-1:0]     cfg_base,
  input  logic [SEG_W-1:0]      cfg_seg_chunks,
  input  logic [SEG_W-1:0]      cfg_nseg,
  input  logic                  cfg_oneshot,
  input  logic [CNT_W-1:0]      cfg_limit,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [CHUNK_BITS-1:0] in_data,
  input  logic [CNT_W-1:0]      in_count,
  output logic                  wr_valid,
  input  logic                  wr_ready,
  output logic [ADDR_W-1:0]     wr_addr,
  output logic [DATA_W-1:0]     wr_data,
  output logic                  wr_last,
  input  logic                  host_ack,
  output logic                  irq,
  output logic [NTF_W-1:0]      notify_cnt,
  output logic                  overflow,
  output logic                  underflow,
  output logic                  done
);
  localparam int BEATS  = CHUNK_BITS / DATA_W;
  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;

  logic                  active_q, full_q;
  logic [BEAT_W-1:0]     beat_q;
  logic [CHUNK_BITS-1:0] hold_q;
  logic [CNT_W-1:0]      bytes_q;
  logic                  done_q, ovf_q, unf_q;
  logic                  fire, last_beat, last_fire, stopping, take, stall;
  logic                  gap, seg_end, behind;
  logic [CNT_W:0]        bytes_next;
  logic [DATA_W-1:0]     lane [BEATS];

  for (genvar g = 0; g < BEATS; g++) begin : g_lane
    assign lane[g] = hold_q[g*DATA_W +: DATA_W];
  end

  assign last_beat  = (beat_q == BEAT_W'(BEATS - 1));
  assign fire       = full_q && wr_ready;
  assign last_fire  = fire && last_beat;
  assign bytes_next = {1'b0, bytes_q} + (CNT_W+1)'(CHUNK_BYTES);
  assign stopping   = last_fire && cfg_oneshot && (bytes_next >= {1'b0, cfg_limit});
  assign in_ready   = active_q && (!full_q || (last_fire && !stopping));
  assign take       = in_valid && in_ready;
  assign stall      = active_q && in_valid && !in_ready;

  assign wr_valid = full_q;
  assign wr_last  = full_q && last_beat;
  assign wr_data  = lane[beat_q];
  assign overflow  = ovf_q;
  assign underflow = unf_q;
  assign done      = done_q;

  cw_count_check #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .restart_i(start), .take_i(take),
    .count_i(in_count), .gap_o(gap)
  );

  cw_addr_gen #(.ADDR_W(ADDR_W), .SEG_W(SEG_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .restart_i(start), .advance_i(last_fire),
    .base_i(cfg_base), .seg_chunks_i(cfg_seg_chunks), .nseg_i(cfg_nseg),
    .addr_o(wr_addr), .seg_end_o(seg_end)
  );

  cw_notify #(.SEG_W(SEG_W), .NTF_W(NTF_W)) u_ntf (
    .clk(clk), .rst_n(rst_n), .restart_i(start), .seg_done_i(seg_end),
    .ack_i(host_ack), .nseg_i(cfg_nseg), .irq_o(irq), .count_o(notify_cnt),
    .behind_o(behind)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      full_q   <= 1'b0;
      beat_q   <= '0;
      bytes_q  <= '0;
      done_q   <= 1'b0;
    end else if (start) begin
      active_q <= 1'b1;
      full_q   <= 1'b0;
      beat_q   <= '0;
      bytes_q  <= '0;
      done_q   <= 1'b0;
    end else begin
      if (take)           full_q <= 1'b1;
      else if (last_fire) full_q <= 1'b0;
      if (fire) beat_q <= last_beat ? '0 : beat_q + BEAT_W'(1);
      if (last_fire) bytes_q <= bytes_next[CNT_W-1:0];
      if (stopping) begin
        active_q <= 1'b0;
        done_q   <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (take) hold_q <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      if (gap || stall)   ovf_q <= 1'b1;
      else if (clr_flags) ovf_q <= 1'b0;
      if (behind)         unf_q <= 1'b1;
      else if (clr_flags) unf_q <= 1'b0;
    end
  end
endmodule

// File: rtl/cw_chunk_writer_chk.sv
module cw_chunk_writer_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int NTF_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              clr_flags,
  input logic [ADDR_W-1:0] cfg_base,
  input logic              in_ready,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              wr_last,
  input logic              irq,
  input logic [NTF_W-1:0]  notify_cnt,
  input logic              overflow,
  input logic              underflow,
  input logic              done
);
  assert_beat_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready && !start) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data) && $stable(wr_last)));

  assert_addr_align_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && cfg_base[4:0] == 5'd0) |-> (wr_addr[4:0] == 5'd0));

  assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !clr_flags) |=> overflow);

  assert_unf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow && !clr_flags) |=> underflow);

  assert_irq_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (notify_cnt == NTF_W'($past(notify_cnt) + 1'b1)));

  assert_done_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !in_ready);
endmodule

bind cw_chunk_writer cw_chunk_writer_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NTF_W(NTF_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .clr_flags(clr_flags),
  .cfg_base(cfg_base), .in_ready(in_ready), .wr_valid(wr_valid),
  .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
  .wr_last(wr_last), .irq(irq), .notify_cnt(notify_cnt),
  .overflow(overflow), .underflow(underflow), .done(done)
);

// File: tb/cw_chunk_writer_tb.sv
module cw_chunk_writer_tb_top;
  localparam int ADDR_W = 32, DATA_W = 64, CNT_W = 32, SEG_W = 8, NTF_W = 16;
  localparam int SEGC = 2, NSEG = 3;

  logic clk = 0, rst_n = 0, start = 0, clr_flags = 0;
  logic [ADDR_W-1:0] cfg_base = 32'h1000;
  logic [SEG_W-1:0]  cfg_seg_chunks = SEGC, cfg_nseg = NSEG;
  logic cfg_oneshot = 0;
  logic [CNT_W-1:0] cfg_limit = 0;
  logic in_valid = 0, in_ready;
  logic [255:0] in_data = '0;
  logic [CNT_W-1:0] in_count = '0;
  logic wr_valid, wr_ready = 0, wr_last;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic host_ack = 0, irq, overflow, underflow, done;
  logic [NTF_W-1:0] notify_cnt;

  int tests = 0, fails = 0, cyc = 0;
  int n_sent = 0, n_ack = 0;
  logic [CNT_W-1:0] last_cnt = '0;
  bit exp_ovf = 0, exp_unf = 0;

  always #4 clk = ~clk;

  cw_chunk_writer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
                    .SEG_W(SEG_W), .NTF_W(NTF_W)) dut_i (.*);

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog expired: actual cycles=%0d expected < 100000", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pbyte(input int idx, input int b);
    return 8'(idx * 37 + b * 3 + 1);
  endfunction

  task automatic do_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    n_sent = 0; n_ack = 0; last_cnt = '0;
  endtask

  task automatic do_clear();
    @(negedge clk); clr_flags = 1;
    @(negedge clk); clr_flags = 0;
    exp_ovf = 0; exp_unf = 0;
  endtask

  task automatic ack();
    host_ack = 1; @(negedge clk); host_ack = 0;
    n_ack++;
  endtask

  // offer a chunk; returns at the negedge after acceptance
  task automatic offer(input int idx, input int step);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    for (int b = 0; b < 32; b++) in_data[b*8 +: 8] = pbyte(idx, b);
    in_count = last_cnt + CNT_W'(step);
    in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    last_cnt = in_count;
    if (step > 32) exp_ovf = 1;
  endtask

  // drain one burst starting at the current negedge
  task automatic drain(input int idx, input bit hold_first);
    int beat = 0, k = 0;
    longint exp_addr;
    exp_addr = 32'h1000 + 32 * (n_sent % (SEGC * NSEG));
    while (beat < 4) begin
      wr_ready = hold_first ? 1'b1 : (((k + n_sent) % 3) != 1);
      #1;
      if (wr_valid && wr_ready) begin
        logic [63:0] e;
        for (int j = 0; j < 8; j++) e[j*8 +: 8] = pbyte(idx, beat * 8 + j);
        chk(wr_addr == exp_addr[31:0], "R3 address", wr_addr, exp_addr);
        chk(wr_data == e, "R1 beat data", wr_data, e);
        chk(wr_last == (beat == 3), "R1 last flag", wr_last, beat == 3);
        beat++;
      end
      k++;
      @(negedge clk);
    end
    wr_ready = 0;
    if ((n_sent % SEGC) == SEGC - 1) begin
      if ((((n_sent / SEGC)) - n_ack) >= NSEG) exp_unf = 1;
      chk(irq == 1, "R7 irq pulse", irq, 1);
    end else begin
      chk(irq == 0, "R7 irq quiet", irq, 0);
    end
    n_sent++;
    chk(notify_cnt == NTF_W'(n_sent / SEGC), "R7 notify count", notify_cnt, n_sent / SEGC);
    chk(overflow == exp_ovf, "R4 overflow flag", overflow, exp_ovf);
    chk(underflow == exp_unf, "R8 underflow flag", underflow, exp_unf);
  endtask

  task automatic chunk(input int idx, input int step, input bit do_ack);
    offer(idx, step);
    drain(idx, 0);
    if (do_ack && irq) ack();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(in_ready == 0 && wr_valid == 0, "R10 reset handshakes", {in_ready, wr_valid}, 0);
    chk(irq == 0 && done == 0 && notify_cnt == 0, "R10 reset notify", notify_cnt, 0);
    chk(overflow == 0 && underflow == 0, "R10 reset flags", {overflow, underflow}, 0);
    rst_n = 1;

    // continuous wraps with prompt acknowledgements
    do_start();
    for (int i = 0; i < 14; i++) chunk(i, 32, 1);

    // count gap of two chunks, then a normal step: stays set
    chunk(14, 64, 1);
    chunk(15, 32, 1);
    chk(overflow == 1, "R6 overflow sticky", overflow, 1);
    do_clear();
    chk(overflow == 0, "R6 overflow cleared", overflow, 0);

    // host falls behind: no acks
    do_start();
    chk(notify_cnt == 0, "R10 start clears notify", notify_cnt, 0);
    for (int i = 0; i < 8; i++) chunk(20 + i, 32, 0);
    chk(underflow == 1, "R8 underflow after fourth segment", underflow, 1);
    do_clear();
    chk(underflow == 0, "R6 underflow cleared", underflow, 0);
    // ack with nothing outstanding after catching up
    for (int i = 0; i < 6; i++) ack();
    chunk(30, 32, 0);
    chunk(31, 32, 0);
    chk(underflow == 0, "R8 no underflow after catch-up", underflow, 0);

    // stall while register full counts as lost data
    do_clear();
    offer(40, 32);
    in_valid = 1;
    #1 chk(in_ready == 0, "R5 register full", in_ready, 0);
    @(negedge clk); in_valid = 0;
    chk(overflow == 1, "R5 stall sets overflow", overflow, 1);
    exp_ovf = 1;
    drain(40, 0);
    do_clear();

    // one-shot limit of three chunks
    cfg_oneshot = 1; cfg_limit = 96;
    do_start();
    chk(in_ready == 1, "R10 start re-arms", in_ready, 1);
    chunk(50, 32, 1);
    chunk(51, 32, 1);
    chk(done == 0 && in_ready == 1, "R9 not yet done", done, 0);
    chunk(52, 32, 1);
    chk(done == 1, "R9 done at limit", done, 1);
    chk(in_ready == 0, "R9 input closed", in_ready, 0);
    do_start();
    chk(done == 0 && in_ready == 1, "R10 start clears done", done, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule